// File: doc/BRIEF.md
# Paged RAM Window Controller

This block lets an 8-bit CPU with a 16-bit address space reach a 1 MB external memory through a 256-byte window at 0xD600-0xD6FF. Two write-only page latches provide the upper twelve bits of a 20-bit memory address. One latch at I/O address 0xD1E0 gives address bits 15-8. The other, at 0xD1E2, gives bits 19-16 in its low nibble and carries the access enable in bit 5. The CPU's own address bits 7-0 give the offset inside the selected page, so any one of 4096 pages can be placed in the window.

The block sits on a simple synchronous bus with read and write strobes. It drives the memory address, a chip select, a write enable and the write data. It returns read data together with an output-enable flag. An indicator output follows the enable bit. When the enable bit is clear, accesses to the window reach neither the memory nor the CPU data bus, so a runaway program cannot corrupt the memory through the window.

Top module: `paged_ram_window`

## Requirements
- R1: After reset both page latches hold zero and the enable bit is clear: `led_on` is 0, and no window access asserts `mem_cs`, `mem_we` or `cpu_rdata_oe`.
- R2: A CPU write to 0xD1E0 loads its data byte into memory address bits 15-8, effective from the cycle after the write.
- R3: A CPU write to 0xD1E2 loads data bits 3-0 into memory address bits 19-16 and data bit 5 into the enable bit. `led_on` equals the stored enable bit.
- R4: While enabled, a read or write at 0xD600-0xD6FF asserts `mem_cs` in the same cycle, with `mem_addr` = {latch 0xD1E2 bits 3-0, latch 0xD1E0, CPU address bits 7-0}. Accesses outside that range never assert `mem_cs`.
- R5: While the enable bit is 0, a write to the window asserts neither `mem_cs` nor `mem_we`, and memory contents are unchanged when read back after re-enabling.
- R6: While enabled, a window read asserts `cpu_rdata_oe` and presents `mem_rdata` on `cpu_rdata`. While disabled, a window read leaves `cpu_rdata_oe` at 0.
- R7: The latches are write-only: a read at 0xD1E0 or 0xD1E2 does not assert `cpu_rdata_oe` and leaves both latches unchanged.
- R8: `mem_we` is asserted only for window writes. A window read asserts `mem_cs` with `mem_we` at 0.
- R9: Pages are distinct: the same window offset in two different pages reaches two different memory locations, including page 0xFFF at offset 0xFF (address 0xFFFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| cpu_rdata_oe | output | 1 | High when the block drives `cpu_rdata` |
| mem_addr | output | 20 | Physical memory address |
| mem_cs | output | 1 | Memory chip select |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Data to memory |
| mem_rdata | input | 8 | Data from memory |
| led_on | output | 1 | Indicator, follows the enable bit |

## Verification
The assertions assume that the CPU never raises read and write in the same cycle, and that strobes and address are held steady over each bus cycle. The stimulus drives one bus cycle per clock, changing everything at the falling edge, and uses only single-strobe cycles or idle cycles, so both assumptions hold. Latch loads are checked only in the cycle after the write edge. Address and data paths are checked while the strobes are stable, well before the next rising edge.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  // decoded view of one CPU bus cycle
  typedef struct packed {
    logic win_hit;   // address falls inside the paged window
    logic rd;
    logic wr;
  } pgw_access_t;

  function automatic logic addr_match(input logic [15:0] a, input logic [15:0] target);
    return (a == target);
  endfunction

endpackage

// File: rtl/pgw_rst_sync.sv
module pgw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pgw_page_regs.sv
module pgw_page_regs
  import pgw_pkg::*;
#(
  parameter int          CPU_AW   = 16,
  parameter int          MID_W    = 8,
  parameter int          HI_W     = 4,
  parameter logic [15:0] MID_ADDR = 16'hD1E0,
  parameter logic [15:0] HI_ADDR  = 16'hD1E2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [MID_W-1:0]  wdata_mid,
  input  logic [HI_W-1:0]   wdata_hi,
  input  logic              wdata_en,
  output logic [MID_W-1:0]  page_mid,
  output logic [HI_W-1:0]   page_hi,
  output logic              enable
);
  logic             ld_mid, ld_hi;
  logic [MID_W-1:0] mid_q, mid_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic             en_q, en_d;

  // next-state
  always_comb begin
    ld_mid = cpu_wr && addr_match(cpu_addr, MID_ADDR);
    ld_hi  = cpu_wr && addr_match(cpu_addr, HI_ADDR);
    mid_d  = mid_q;
    hi_d   = hi_q;
    en_d   = en_q;
    if (ld_mid) mid_d = wdata_mid;
    if (ld_hi) begin
      hi_d = wdata_hi;
      en_d = wdata_en;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= '0;
      hi_q  <= '0;
      en_q  <= 1'b0;
    end else begin
      mid_q <= mid_d;
      hi_q  <= hi_d;
      en_q  <= en_d;
    end
  end

  assign page_mid = mid_q;
  assign page_hi  = hi_q;
  assign enable   = en_q;

  // R2: middle page byte only changes on its own write
  a_r2_mid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_mid |=> $stable(mid_q));
  // R3: high nibble and enable only change on the 0xD1E2 write
  a_r3_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_hi |=> ($stable(hi_q) && $stable(en_q)));
  // R3: enable captures data bit on load
  a_r3_en_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi |=> (en_q == $past(wdata_en)));
endmodule

// File: rtl/pgw_window_decode.sv
module pgw_window_decode
  import pgw_pkg::*;
#(
  parameter int         CPU_AW = 16,
  parameter int         OFF_W  = 8,
  parameter int         DW     = 8,
  parameter logic [7:0] WIN_HI = 8'hD6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              enable,
  input  logic [DW-1:0]     mem_rdata,
  output logic              mem_cs,
  output logic              mem_we,
  output logic              rd_oe,
  output logic [DW-1:0]     rd_data
);
  localparam int SEL_W = CPU_AW - OFF_W;

  pgw_access_t acc;

  always_comb begin
    acc.win_hit = (cpu_addr[CPU_AW-1:OFF_W] == WIN_HI[SEL_W-1:0]);
    acc.rd      = cpu_rd;
    acc.wr      = cpu_wr;
    mem_cs      = enable && acc.win_hit && (acc.rd || acc.wr);
    mem_we      = enable && acc.win_hit && acc.wr;
    rd_oe       = enable && acc.win_hit && acc.rd;
    rd_data     = rd_oe ? mem_rdata : '0;
  end

  // input assumption: one strobe per bus cycle
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd && cpu_wr));
  // R8: a read never produces a memory write
  a_r8_rd_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |-> !mem_we);
  // R5: disabled window never selects memory
  a_r5_off_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!mem_cs && !rd_oe));
endmodule

// File: rtl/paged_ram_window.sv
module paged_ram_window
  import pgw_pkg::*;
#(
  parameter int          CPU_AW   = 16,
  parameter int          DW       = 8,
  parameter int          MEM_AW   = 20,
  parameter int          OFF_W    = 8,
  parameter int          EN_BIT   = 5,
  parameter logic [15:0] MID_ADDR = 16'hD1E0,
  parameter logic [15:0] HI_ADDR  = 16'hD1E2,
  parameter logic [7:0]  WIN_HI   = 8'hD6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_cs,
  output logic              mem_we,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              led_on
);
  localparam int MID_W = DW;
  localparam int HI_W  = MEM_AW - OFF_W - MID_W;

  logic             rst_sync_n;
  logic [MID_W-1:0] page_mid;
  logic [HI_W-1:0]  page_hi;
  logic             enable;

  pgw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pgw_page_regs #(
    .CPU_AW  (CPU_AW), .MID_W (MID_W), .HI_W (HI_W),
    .MID_ADDR(MID_ADDR), .HI_ADDR(HI_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .wdata_mid (cpu_wdata),
    .wdata_hi  (cpu_wdata[HI_W-1:0]),
    .wdata_en  (cpu_wdata[EN_BIT]),
    .page_mid  (page_mid),
    .page_hi   (page_hi),
    .enable    (enable)
  );

  pgw_window_decode #(
    .CPU_AW(CPU_AW), .OFF_W(OFF_W), .DW(DW), .WIN_HI(WIN_HI)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .enable    (enable),
    .mem_rdata (mem_rdata),
    .mem_cs    (mem_cs),
    .mem_we    (mem_we),
    .rd_oe     (cpu_rdata_oe),
    .rd_data   (cpu_rdata)
  );

  assign mem_addr  = {page_hi, page_mid, cpu_addr[OFF_W-1:0]};
  assign mem_wdata = cpu_wdata;
  assign led_on    = enable;

  // R4: memory is selected only while the indicator shows enabled
  a_r4_cs_needs_led: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_cs |-> led_on);
  // R6: bus is driven only for reads
  a_r6_oe_needs_rd: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_rdata_oe |-> (cpu_rd && mem_cs));
  // R7: a read cycle never moves the page bits
  a_r7_rd_keeps_page: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_rd && !cpu_wr) |=> $stable(mem_addr[MEM_AW-1:OFF_W]));
endmodule

// File: tb/paged_ram_window_tb_top.sv
module paged_ram_window_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_rdata;
  logic        cpu_rdata_oe;
  logic [19:0] mem_addr;
  logic        mem_cs, mem_we;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        led_on;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  paged_ram_window dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .cpu_rdata_oe(cpu_rdata_oe), .mem_addr(mem_addr), .mem_cs(mem_cs),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .led_on(led_on)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // behavioural memory
  logic [7:0] mem_model [int];
  always @(posedge clk) if (mem_cs && mem_we) mem_model[int'(mem_addr)] = mem_wdata;
  always_comb begin
    if (mem_model.exists(int'(mem_addr))) mem_rdata = mem_model[int'(mem_addr)];
    else                                   mem_rdata = 8'h00;
  end

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        rd;
    logic        wr;
    logic        ecs;
    logic        ewe;
    logic        eoe;
    logic [19:0] emaddr;
    logic [7:0]  erdata;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{16'hD1E0, 8'h34, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h0,     8'h00, 4'd2}, // R2 load mid
    '{16'hD1E2, 8'h2A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h0,     8'h00, 4'd3}, // R3 hi=A, en
    '{16'hD611, 8'h5C, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 20'hA3411, 8'h00, 4'd4}, // R4 window write
    '{16'hD611, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 20'hA3411, 8'h5C, 4'd6}, // R6/R8 read
    '{16'hD1E0, 8'h35, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h0,     8'h00, 4'd2},
    '{16'hD611, 8'h66, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 20'hA3511, 8'h00, 4'd9}, // R9 other page
    '{16'hD611, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 20'hA3511, 8'h66, 4'd9},
    '{16'hD700, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0,     8'h00, 4'd4}, // R4 above window
    '{16'hD5FF, 8'h99, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h0,     8'h00, 4'd4}, // R4 below window
    '{16'hD1E2, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0,     8'h00, 4'd7}, // R7 latch read
    '{16'hD1E2, 8'h0A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h0,     8'h00, 4'd3}, // R3 disable
    '{16'hD611, 8'h77, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h0,     8'h00, 4'd5}, // R5 blocked write
    '{16'hD611, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0,     8'h00, 4'd6}, // R6 blocked read
    '{16'hD1E2, 8'h2A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h0,     8'h00, 4'd3},
    '{16'hD611, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 20'hA3511, 8'h66, 4'd5}, // R5 unchanged
    '{16'hD1E0, 8'h34, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h0,     8'h00, 4'd2},
    '{16'hD611, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 20'hA3411, 8'h5C, 4'd9},
    '{16'hD1E0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h0,     8'h00, 4'd2},
    '{16'hD1E2, 8'h3F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h0,     8'h00, 4'd3},
    '{16'hD6FF, 8'h11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 20'hFFFFF, 8'h00, 4'd9}, // R9 top address
    '{16'hD6FF, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 20'hFFFFF, 8'h11, 4'd9}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one bus cycle at the falling edge, sample combinational outputs 1 ns later
  task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic r, input logic w);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rd = r; cpu_wr = w;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    #1;
    check("R1 led after reset", led_on, 1'b0);
    bus(16'hD620, 8'hAB, 1'b0, 1'b1);
    check("R1 no cs on window write", {mem_cs, mem_we}, 2'b00);
    bus(16'hD620, 8'h00, 1'b1, 1'b0);
    check("R1 no oe on window read", cpu_rdata_oe, 1'b0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i].addr, VEC[i].wdata, VEC[i].rd, VEC[i].wr);
      check($sformatf("R%0d vec %0d cs", VEC[i].req, i), mem_cs, VEC[i].ecs);
      check($sformatf("R%0d vec %0d we", VEC[i].req, i), mem_we, VEC[i].ewe);
      check($sformatf("R%0d vec %0d oe", VEC[i].req, i), cpu_rdata_oe, VEC[i].eoe);
      if (VEC[i].ecs)
        check($sformatf("R%0d vec %0d addr", VEC[i].req, i), mem_addr, VEC[i].emaddr);
      if (VEC[i].eoe)
        check($sformatf("R%0d vec %0d rdata", VEC[i].req, i), cpu_rdata, VEC[i].erdata);
    end

    // R3 indicator follows enable bit
    bus(16'hD1E2, 8'h20, 1'b0, 1'b1);
    idle();
    check("R3 led set", led_on, 1'b1);
    bus(16'hD1E2, 8'hDF, 1'b0, 1'b1);
    idle();
    check("R3 led clear with other bits set", led_on, 1'b0);

    // R7 latch reads leave pages intact: set page 0x5 0x12, read latches, probe window
    bus(16'hD1E0, 8'h12, 1'b0, 1'b1);
    bus(16'hD1E2, 8'h25, 1'b0, 1'b1);
    bus(16'hD1E0, 8'h00, 1'b1, 1'b0);
    check("R7 no oe on 0xD1E0 read", cpu_rdata_oe, 1'b0);
    bus(16'hD1E2, 8'h00, 1'b1, 1'b0);
    bus(16'hD6A0, 8'h00, 1'b1, 1'b0);
    check("R7 page kept after latch reads", mem_addr, 20'h512A0);

    // R1 mid-run reset clears latches
    do_reset();
    #1;
    check("R1 led cleared by reset", led_on, 1'b0);
    bus(16'hD645, 8'h01, 1'b0, 1'b1);
    check("R1 window blocked after reset", mem_cs, 1'b0);
    bus(16'hD1E2, 8'h20, 1'b0, 1'b1);
    bus(16'hD645, 8'h00, 1'b1, 1'b0);
    check("R1 pages zero after reset", mem_addr, 20'h00045);
    check("R8 read without we", {mem_cs, mem_we}, 2'b10);
    idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule